// File: doc/BRIEF.md
# Interval-Bounded Progressive Block Adder

This block adds or subtracts two 32-bit unsigned operands and exposes the result as a closing interval instead of a single value. Both operands are cut into eight 4-bit blocks. Each block pair addresses a small internal table whose entry holds the block sum with carry-in 0 and with carry-in 1. The blocks are stitched together by carry-select. Every cycle the block presents a lower and an upper bound that are certain to contain the exact result.

The refinement starts at the most significant end. After a start pulse the stage counter reads 0 and no block boundary counts as settled. Each following cycle settles the incoming carry of one more block, moving toward the least significant block. The gap between the bounds shrinks by one digit each time, and after eight steps the bounds meet.

A caller that runs out of time, or that already has a narrow enough interval, raises stop. The current bounds then stay readable until the next start.

Top module: `interval_block_adder`

## Requirements
- R1: After reset, stage is 0, done is 0, and both bounds are 0.
- R2: A start pulse captures opa, opb and sub_en. On the following cycle, stage reads 0, done reads 0, and the bounds are those of stage 0.
- R3: While a run is active and stop is low, stage rises by exactly one per clock until it reaches 8.
- R4: Both bounds are 35-bit two's complement values. Block i is bits 4i+3..4i. With c_i the true carry into block i (c_0 = sub_en), the lower bound at stage s equals exact − Σ c_i·16^i over i < 8−s.
- R5: At stage s, upper − lower = Σ 16^i over i < 8−s, which is 0x11111111 at stage 0. At every stage, lower ≤ exact ≤ upper.
- R6: With sub_en = 0 the exact value is opa + opb. With sub_en = 1 it is opa + (bitwise inverse of opb) + 1. In both cases it is a 33-bit unsigned value whose bit 32 is the carry out.
- R7: Stage reaches 8 exactly eight cycles after it reads 0. In that cycle done is 1 and lower = upper = exact.
- R8: If stop is high at a clock edge during a run, stage and both bounds keep their values and done stays 0 until the next start.
- R9: Once done is 1, stage, done and the bounds hold until the next start, even when stop pulses.
- R10: A start at the same edge as stop, or in the middle of a run, restarts at stage 0 with the new operands, and the stop of that edge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new operation with the present operands |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| sub_en | input | 1 | 1 selects opa − opb, 0 selects opa + opb |
| stop | input | 1 | Halt refinement and keep the current bounds |
| done | output | 1 | All carries settled; the bounds are equal |
| stage | output | 4 | Number of settled block boundaries, 0 to 8 |
| lower_bnd | output | 35 | Lower bound, two's complement |
| upper_bnd | output | 35 | Upper bound, two's complement |

## Verification
Two events can land on the same edge: the start of a new operation and a stop request. The bench raises both together in the middle of a run with fresh operands. It expects stage 0 with the new operands' bounds, and it expects the steps to keep advancing afterwards. The bench also pulses stop after done to confirm that a finished result does not move. Bounds are compared at every stage against a carry model built from masked operand sums, using operands with long carry and borrow chains.

// File: rtl/ipa_pkg.sv
package ipa_pkg;

    // Default geometry: 32-bit operands cut into 4-bit blocks
    localparam int DEF_DATA_W = 32;
    localparam int DEF_BLK_W  = 4;

    // Number of blocks for a given geometry
    function automatic int blk_count(input int data_w, input int blk_w);
        return data_w / blk_w;
    endfunction

    // Stage counter width: holds 0..blocks inclusive
    function automatic int stage_width(input int data_w, input int blk_w);
        return $clog2(data_w / blk_w + 1);
    endfunction

endpackage

// File: rtl/ipa_block_lut.sv
// ipa_block_lut
//   Combinational table for one block pair. The table is addressed by the two
//   BLK_W-bit slices. Each entry holds the (BLK_W+1)-bit sum with carry-in 0
//   and the sum with carry-in 1.
//   Assumes: BLK_W small enough that 2^(2*BLK_W) entries stay modest.
module ipa_block_lut #(
    parameter int BLK_W = 4
) (
    input  logic [BLK_W-1:0] x_blk,
    input  logic [BLK_W-1:0] y_blk,
    output logic [BLK_W:0]   sum_c0,
    output logic [BLK_W:0]   sum_c1
);
    localparam int ADDR_W = 2 * BLK_W;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int ENT_W  = 2 * (BLK_W + 1);

    logic [ENT_W-1:0] rom [DEPTH];
    logic [ADDR_W-1:0] addr;
    logic [ENT_W-1:0]  entry;

    // Fill every table cell from its own address
    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam logic [ADDR_W-1:0] A = ADDR_W'(g);
        localparam logic [BLK_W:0] S0 =
            {1'b0, A[ADDR_W-1:BLK_W]} + {1'b0, A[BLK_W-1:0]};
        localparam logic [BLK_W:0] S1 = S0 + (BLK_W+1)'(1);
        assign rom[g] = {S0, S1};
    end

    // Table read: the address is the concatenation of both slices
    always_comb begin
        addr   = {x_blk, y_blk};
        entry  = rom[addr];
        sum_c0 = entry[ENT_W-1:BLK_W+1];
        sum_c1 = entry[BLK_W:0];
    end
endmodule

// File: rtl/ipa_carry_select.sv
// ipa_carry_select
//   Chooses each block's version from the carry out of the block below. It
//   produces the true carry into every block and the true sum digits.
//   Assumes: sum_c1 = sum_c0 + 1 per block, as the table guarantees.
module ipa_carry_select #(
    parameter int NBLK  = 8,
    parameter int BLK_W = 4
) (
    input  logic [NBLK-1:0][BLK_W:0] sum_c0,
    input  logic [NBLK-1:0][BLK_W:0] sum_c1,
    input  logic                     cin,
    output logic [NBLK:0]            carry,
    output logic [NBLK*BLK_W-1:0]    digits
);
    assign carry[0] = cin;

    // One select stage per block: carry out and digit follow the carry in
    for (genvar i = 0; i < NBLK; i++) begin : g_sel
        assign carry[i+1] = carry[i] ? sum_c1[i][BLK_W] : sum_c0[i][BLK_W];
        assign digits[i*BLK_W +: BLK_W] =
            carry[i] ? sum_c1[i][BLK_W-1:0] : sum_c0[i][BLK_W-1:0];
    end
endmodule

// File: rtl/ipa_bound_gen.sv
// ipa_bound_gen
//   Forms both bounds for a given stage. Blocks below index NBLK-stage have an
//   unsettled carry-in. The lower bound withholds their true carries, and the
//   upper bound credits a full unit for each of them.
//   Assumes: BND_W >= data width + 3 so negative lows and high ups fit.
module ipa_bound_gen #(
    parameter int NBLK  = 8,
    parameter int BLK_W = 4,
    parameter int STG_W = 4,
    parameter int BND_W = 35
) (
    input  logic [NBLK*BLK_W-1:0] digits,
    input  logic [NBLK:0]         carry,
    input  logic [STG_W-1:0]      stage,
    output logic [BND_W-1:0]      lower,
    output logic [BND_W-1:0]      upper
);
    localparam int DATA_W = NBLK * BLK_W;

    logic [BND_W-1:0] exact;
    logic [BND_W-1:0] withheld;
    logic [BND_W-1:0] gap;

    // Sum the withheld carries and the unit gap over the unsettled blocks
    always_comb begin
        exact    = BND_W'({carry[NBLK], digits});
        withheld = '0;
        gap      = '0;
        for (int i = 0; i < NBLK; i++) begin
            if (i < NBLK - int'(stage)) begin
                withheld = withheld + (BND_W'(carry[i]) << (BLK_W * i));
                gap      = gap + (BND_W'(1) << (BLK_W * i));
            end
        end
        lower = exact - withheld;
        upper = lower + gap;
    end

    logic unused_ok;
    assign unused_ok = ^{DATA_W};
endmodule

// File: rtl/ipa_stage_ctrl.sv
// ipa_stage_ctrl
//   Sequences a run. Start resets the stage to 0 and wins over stop. Each later
//   cycle settles one more block until all NBLK blocks are settled or stop halts.
//   Assumes: synchronous active-low reset.
module ipa_stage_ctrl #(
    parameter int NBLK  = 8,
    parameter int STG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    output logic [STG_W-1:0] stage_q,
    output logic [STG_W-1:0] stage_nxt,
    output logic             load,
    output logic             run_q,
    output logic             done_q
);
    localparam logic [STG_W-1:0] LAST = STG_W'(NBLK);

    // Next stage and the bound-register load enable
    always_comb begin
        load      = start || (run_q && !stop);
        stage_nxt = stage_q;
        if (start)
            stage_nxt = '0;
        else if (run_q && !stop)
            stage_nxt = stage_q + STG_W'(1);
    end

    // Stage, run and done registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            run_q   <= 1'b0;
            done_q  <= 1'b0;
        end else if (start) begin
            stage_q <= '0;
            run_q   <= 1'b1;
            done_q  <= 1'b0;
        end else if (run_q) begin
            if (stop) begin
                run_q <= 1'b0;
            end else begin
                stage_q <= stage_nxt;
                if (stage_nxt == LAST) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/interval_block_adder.sv
// interval_block_adder
//   Top level. Captures the operands at start and runs the block tables and the
//   carry-select chain. Each cycle it registers bounds for the next stage until
//   they meet or stop arrives.
//   Assumes: DATA_W divisible by BLK_W; BLK_W small (table per block).
module interval_block_adder #(
    parameter int DATA_W = ipa_pkg::DEF_DATA_W,
    parameter int BLK_W  = ipa_pkg::DEF_BLK_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [DATA_W-1:0]       opa,
    input  logic [DATA_W-1:0]       opb,
    input  logic                    sub_en,
    input  logic                    stop,
    output logic                    done,
    output logic [$clog2(DATA_W/BLK_W+1)-1:0] stage,
    output logic [DATA_W+2:0]       lower_bnd,
    output logic [DATA_W+2:0]       upper_bnd
);
    localparam int NBLK  = ipa_pkg::blk_count(DATA_W, BLK_W);
    localparam int STG_W = ipa_pkg::stage_width(DATA_W, BLK_W);
    localparam int BND_W = DATA_W + 3;

    logic [DATA_W-1:0] opa_q, opb_q;
    logic              sub_q;
    logic [DATA_W-1:0] sel_a, sel_b, b_eff;
    logic              sel_sub;

    logic [STG_W-1:0]  stage_q, stage_nxt;
    logic              load, run_q, done_q;

    logic [NBLK-1:0][BLK_W:0] sum_c0, sum_c1;
    logic [NBLK:0]            carry;
    logic [DATA_W-1:0]        digits;
    logic [BND_W-1:0]         low_nxt, up_nxt;
    logic [BND_W-1:0]         low_q, up_q;

    // Operand capture on start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opa_q <= '0;
            opb_q <= '0;
            sub_q <= 1'b0;
        end else if (start) begin
            opa_q <= opa;
            opb_q <= opb;
            sub_q <= sub_en;
        end
    end

    // Operand source: the ports on a start edge, the captured copy otherwise
    always_comb begin
        sel_a   = start ? opa    : opa_q;
        sel_b   = start ? opb    : opb_q;
        sel_sub = start ? sub_en : sub_q;
        b_eff   = sel_b ^ {DATA_W{sel_sub}};
    end

    ipa_stage_ctrl #(.NBLK(NBLK), .STG_W(STG_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .stop      (stop),
        .stage_q   (stage_q),
        .stage_nxt (stage_nxt),
        .load      (load),
        .run_q     (run_q),
        .done_q    (done_q)
    );

    for (genvar i = 0; i < NBLK; i++) begin : g_blk
        ipa_block_lut #(.BLK_W(BLK_W)) u_lut (
            .x_blk  (sel_a[i*BLK_W +: BLK_W]),
            .y_blk  (b_eff[i*BLK_W +: BLK_W]),
            .sum_c0 (sum_c0[i]),
            .sum_c1 (sum_c1[i])
        );
    end

    ipa_carry_select #(.NBLK(NBLK), .BLK_W(BLK_W)) u_csel (
        .sum_c0 (sum_c0),
        .sum_c1 (sum_c1),
        .cin    (sel_sub),
        .carry  (carry),
        .digits (digits)
    );

    ipa_bound_gen #(.NBLK(NBLK), .BLK_W(BLK_W), .STG_W(STG_W), .BND_W(BND_W)) u_bnd (
        .digits (digits),
        .carry  (carry),
        .stage  (stage_nxt),
        .lower  (low_nxt),
        .upper  (up_nxt)
    );

    // Bound registers: refreshed on start and on every advancing cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q <= '0;
            up_q  <= '0;
        end else if (load) begin
            low_q <= low_nxt;
            up_q  <= up_nxt;
        end
    end

    assign stage     = stage_q;
    assign done      = done_q;
    assign lower_bnd = low_q;
    assign upper_bnd = up_q;
endmodule

// File: rtl/interval_block_adder_chk.sv
// interval_block_adder_chk
//   Temporal checks on the adder's ports and run state, bound into the top.
module interval_block_adder_chk #(
    parameter int NBLK  = 8,
    parameter int STG_W = 4,
    parameter int BND_W = 35
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             stop,
    input logic             run_q,
    input logic             done,
    input logic [STG_W-1:0] stage,
    input logic [BND_W-1:0] lower_bnd,
    input logic [BND_W-1:0] upper_bnd
);
    // R3
    stage_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !start && !stop) |=> (stage == $past(stage) + STG_W'(1)));

    // R5
    bound_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $signed(lower_bnd) <= $signed(upper_bnd));

    // R7
    done_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lower_bnd == upper_bnd && stage == STG_W'(NBLK)));

    // R8
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && stop && !start) |=> ($stable(stage) && $stable(lower_bnd)
                                        && $stable(upper_bnd) && !done));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !start) |=> ($stable(stage) && $stable(lower_bnd)
                                 && $stable(upper_bnd) && $stable(done)));

    // R10
    start_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (stage == '0 && !done && run_q));
endmodule

bind interval_block_adder interval_block_adder_chk #(
    .NBLK  (NBLK),
    .STG_W (STG_W),
    .BND_W (BND_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .stop      (stop),
    .run_q     (run_q),
    .done      (done),
    .stage     (stage),
    .lower_bnd (lower_bnd),
    .upper_bnd (upper_bnd)
);

// File: tb/interval_block_adder_tb.sv
`timescale 1ns/1ps
module interval_block_adder_tb;
    localparam int DW  = 32;
    localparam int BW  = 4;
    localparam int NB  = DW / BW;
    localparam int BND = DW + 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          stop = 1'b0;
    logic          sub_en = 1'b0;
    logic [DW-1:0] opa = '0, opb = '0;
    logic          done;
    logic [3:0]    stage;
    logic [BND-1:0] lower_bnd, upper_bnd;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    interval_block_adder u_dut (
        .clk (clk), .rst_n (rst_n), .start (start), .opa (opa), .opb (opb),
        .sub_en (sub_en), .stop (stop), .done (done), .stage (stage),
        .lower_bnd (lower_bnd), .upper_bnd (upper_bnd)
    );

    function automatic longint eff_b(input longint b, input bit sub);
        return sub ? ((~b) & 64'hFFFF_FFFF) : b;
    endfunction

    // R6 exact value
    function automatic longint exact_of(input longint a, input longint b, input bit sub);
        return a + eff_b(b, sub) + longint'(sub);
    endfunction

    // true carry into block i from masked low-order sums
    function automatic longint carry_in(input longint a, input longint b, input bit sub, input int i);
        longint m = (64'd1 << (BW * i)) - 1;
        return ((a & m) + (eff_b(b, sub) & m) + longint'(sub)) >> (BW * i);
    endfunction

    function automatic longint gap_of(input int s);
        longint g = 0;
        for (int i = 0; i < NB - s; i++) g += 64'd1 << (BW * i);
        return g;
    endfunction

    function automatic longint low_of(input longint a, input longint b, input bit sub, input int s);
        longint l = exact_of(a, b, sub);
        for (int i = 0; i < NB - s; i++) l -= carry_in(a, b, sub, i) << (BW * i);
        return l;
    endfunction

    function automatic longint sx(input logic [BND-1:0] v);
        return longint'($signed(v));
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Full comparison at stage s
    task automatic check_stage(input longint a, input longint b, input bit sub, input int s, input bit exp_done);
        longint lo = sx(lower_bnd);
        longint up = sx(upper_bnd);
        longint ex = exact_of(a, b, sub);
        check("R3 stage", longint'(stage), longint'(s));
        check("R4 lower", lo, low_of(a, b, sub, s));
        check("R5 gap", up - lo, gap_of(s));
        check("R5 enclose", longint'(lo <= ex && ex <= up), 1);
        check("R7 done", longint'(done), longint'(exp_done));
    endtask

    task automatic launch(input longint a, input longint b, input bit sub);
        @(negedge clk);
        opa = a[DW-1:0]; opb = b[DW-1:0]; sub_en = sub; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Full run, all nine stages, then hold after done
    task automatic full_run(input longint a, input longint b, input bit sub);
        launch(a, b, sub);
        check_stage(a, b, sub, 0, 1'b0);   // R2
        for (int s = 1; s <= NB; s++) begin
            @(negedge clk);
            check_stage(a, b, sub, s, s == NB);
        end
        check("R7 meet", sx(lower_bnd), exact_of(a, b, sub));
        check("R6 exact", sx(upper_bnd), exact_of(a, b, sub));
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        longint ra, rb, hl, hu;
        int seed = 7;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 stage", longint'(stage), 0);
        check("R1 done", longint'(done), 0);
        check("R1 lower", sx(lower_bnd), 0);
        check("R1 upper", sx(upper_bnd), 0);
        rst_n = 1'b1;

        // Directed corners: long carry and borrow chains, extremes
        full_run(64'hFFFF_FFFF, 64'h1, 1'b0);
        full_run(64'h0, 64'h0, 1'b0);
        full_run(64'hFFFF_FFFF, 64'hFFFF_FFFF, 1'b0);
        full_run(64'h0, 64'h0, 1'b1);            // R6 0 - 0
        full_run(64'h0, 64'h1, 1'b1);            // R6 borrow ripples through all blocks
        full_run(64'h1234_5678, 64'h1234_5678, 1'b1);
        full_run(64'h0FFF_FFFF, 64'h1, 1'b0);
        full_run(64'h8000_0000, 64'h8000_0000, 1'b0);

        // R9: stop after done has no effect
        hl = sx(lower_bnd); hu = sx(upper_bnd);
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 stage", longint'(stage), NB);
        check("R9 done", longint'(done), 1);
        check("R9 lower", sx(lower_bnd), hl);
        check("R9 upper", sx(upper_bnd), hu);

        // Random operands, both modes
        for (int k = 0; k < 30; k++) begin
            ra = longint'($urandom());
            rb = longint'($urandom());
            full_run(ra, rb, k[0]);
        end

        // R8: stop halts at stage 3
        ra = 64'h0F0F_FFFF; rb = 64'h0000_0001;
        launch(ra, rb, 1'b0);
        for (int s = 1; s <= 3; s++) @(negedge clk);
        check_stage(ra, rb, 1'b0, 3, 1'b0);
        stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        check_stage(ra, rb, 1'b0, 3, 1'b0);   // R8 frozen
        repeat (4) @(negedge clk);
        check_stage(ra, rb, 1'b0, 3, 1'b0);   // R8 still frozen

        // R10: start and stop on the same edge during a run
        ra = 64'hFFFF_0000; rb = 64'h0001_FFFF;
        launch(ra, rb, 1'b0);
        @(negedge clk); @(negedge clk);
        opa = 32'h0000_0010; opb = 32'h0000_0011; sub_en = 1'b1;
        start = 1'b1; stop = 1'b1;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        check_stage(64'h10, 64'h11, 1'b1, 0, 1'b0);   // R10 restart
        for (int s = 1; s <= NB; s++) begin
            @(negedge clk);
            check_stage(64'h10, 64'h11, 1'b1, s, s == NB);  // R10 continues
        end

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule